// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block gives software a small window of local registers through which it reaches a remote register space. Software writes the target address and, for a write, the data into their own local registers. It then writes the control/status register to start one transaction. Bit 0 of that same write picks the direction. The block copies the address and data into its sequencer and raises a request on a simple remote port. It holds that request unchanged until the remote side acknowledges.

Software finds out that the transaction has finished by polling a ready flag in the control/status register. After a read, the fetched value is available in a read-only read-data register. A further local register holds a parity/control field, which is driven to the remote port at all times. A control write that arrives while a transaction is still outstanding is dropped, and a sticky error flag records it.

The window offsets are fixed:

| Offset | Register |
|---|---|
| 0 | target address |
| 1 | write data |
| 2 | read data |
| 3 | control/status |
| 4 | parity/control field |

Reads of offsets 5 to 7 return zero. When the control/status register is read, its bits are:

- bit 0: direction of the last accepted transaction
- bit 1: ready
- bit 2: error

Top module: `reg_window_bridge`

## Requirements
- R1: After reset, the control/status register reads ready=1 (bit 1) and error=0 (bit 2). Offsets 0, 1, 2 and 4 read zero.
- R2: A host write to offset 0, 1 or 4 stores the value, truncated to the register's width, and it reads back at the same offset.
- R3: A control write (offset 3) with bit 0 = 1, made while idle, starts a remote write. In the cycle after the write, rmt_req=1, rmt_we=1, and rmt_addr and rmt_wdata equal the latched address and write data.
- R4: A control write with bit 0 = 0, made while idle, starts a remote read of the latched address with rmt_we=0. The rmt_rdata present in the acknowledge cycle is stored and reads at offset 2 once ready is set.
- R5: Ready reads 0 from the cycle after a launching write. It stays 0 while the request is pending, and it reads 1 in the cycle after rmt_ack is sampled with rmt_req high.
- R6: A control write while busy is ignored. The pending request keeps its direction and address, no second transaction follows, and the error bit becomes 1.
- R7: Once set, the error bit stays 1 through later transactions until reset.
- R8: rmt_ctl always equals the value held in the parity/control register (offset 4).
- R9: Writing offsets 0 or 1 while a transaction is pending does not change rmt_addr or rmt_wdata before the acknowledge.
- R10: A remote write leaves the read-data register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_ofs | input | 3 | Window register offset |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Read value of the register at host_ofs (combinational) |
| rmt_req | output | 1 | Remote request, held until acknowledged |
| rmt_we | output | 1 | Remote direction: 1 write, 0 read |
| rmt_addr | output | AW | Remote register address |
| rmt_wdata | output | DW | Remote write data |
| rmt_ctl | output | PW | Parity/control field toward the remote side |
| rmt_ack | input | 1 | Remote acknowledge |
| rmt_rdata | input | DW | Remote read data, valid with rmt_ack |

## Verification
The assertions assume three things about the remote side. It asserts rmt_ack only while rmt_req is high. It pulses rmt_ack for a single cycle. It presents valid rmt_rdata in that same cycle. The assertions also assume that the host writes at most one register per cycle. The bench's remote model waits a random delay, answers with a one-cycle pulse, and clears it before the request could rise again. The model can also withhold the acknowledge so that control writes can be aimed at a pending transaction.

// File: rtl/brw_pkg.sv
package brw_pkg;
    typedef enum logic [2:0] {
        OFS_ADDR  = 3'd0,
        OFS_WDATA = 3'd1,
        OFS_RDATA = 3'd2,
        OFS_CSR   = 3'd3,
        OFS_PAR   = 3'd4
    } win_ofs_e;

    localparam int CSR_DIR_BIT = 0;
    localparam int CSR_RDY_BIT = 1;
    localparam int CSR_ERR_BIT = 2;
endpackage

// File: rtl/brw_window.sv
module brw_window
    import brw_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [2:0]    ofs,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdat_q,
    output logic [PW-1:0] par_q,
    output logic          launch,
    output logic          launch_dir,
    input  logic [DW-1:0] rd_val,
    input  logic          ready,
    input  logic          err,
    input  logic          dir
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] wdat;
        logic [PW-1:0] par;
    } win_t;

    win_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            case (win_ofs_e'(ofs))
                OFS_ADDR:  st_d.addr = wdata[AW-1:0];
                OFS_WDATA: st_d.wdat = wdata;
                OFS_PAR:   st_d.par  = wdata[PW-1:0];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_q     = st_q.addr;
    assign wdat_q     = st_q.wdat;
    assign par_q      = st_q.par;
    assign launch     = wr && (win_ofs_e'(ofs) == OFS_CSR);
    assign launch_dir = wdata[CSR_DIR_BIT];

    always_comb begin
        rdata = '0;
        case (win_ofs_e'(ofs))
            OFS_ADDR:  rdata[AW-1:0] = st_q.addr;
            OFS_WDATA: rdata = st_q.wdat;
            OFS_RDATA: rdata = rd_val;
            OFS_CSR: begin
                rdata[CSR_DIR_BIT] = dir;
                rdata[CSR_RDY_BIT] = ready;
                rdata[CSR_ERR_BIT] = err;
            end
            OFS_PAR:   rdata[PW-1:0] = st_q.par;
            default:   rdata = '0;
        endcase
    end

    // R2: a stored address write shows up on the next cycle
    a_r2_addr_store: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && ofs == 3'd0) |=> addr_q == $past(wdata[AW-1:0]));
    // R8: parity field only changes on a write to its offset
    a_r8_par_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && ofs == 3'd4) |=> $stable(par_q));
endmodule

// File: rtl/brw_seq.sv
module brw_seq #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic          launch_dir,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] wdat_in,
    output logic          rmt_req,
    output logic          rmt_we,
    output logic [AW-1:0] rmt_addr,
    output logic [DW-1:0] rmt_wdata,
    input  logic          rmt_ack,
    input  logic [DW-1:0] rmt_rdata,
    output logic          ready,
    output logic          err,
    output logic          dir,
    output logic [DW-1:0] rd_val
);
    typedef struct packed {
        logic          busy;
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdat;
        logic [DW-1:0] rdv;
        logic          err;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (launch) st_d.err = 1'b1;
            if (rmt_ack) begin
                st_d.busy = 1'b0;
                if (!st_q.we) st_d.rdv = rmt_rdata;
            end
        end else if (launch) begin
            st_d.busy = 1'b1;
            st_d.we   = launch_dir;
            st_d.addr = addr_in;
            st_d.wdat = wdat_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rmt_req   = st_q.busy;
    assign rmt_we    = st_q.we;
    assign rmt_addr  = st_q.addr;
    assign rmt_wdata = st_q.wdat;
    assign ready     = !st_q.busy;
    assign err       = st_q.err;
    assign dir       = st_q.we;
    assign rd_val    = st_q.rdv;

    // R3: request and its payload hold until acknowledged
    a_r3_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (rmt_req && !rmt_ack) |=> (rmt_req && $stable(rmt_addr) && $stable(rmt_wdata) && $stable(rmt_we)));
    // R4: read data captured from the acknowledge cycle
    a_r4_rd_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (rmt_req && rmt_ack && !rmt_we) |=> rd_val == $past(rmt_rdata));
    // R5: ready drops after an idle launch and rises after ack
    a_r5_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && ready) |=> !ready);
    a_r5_ready_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (rmt_req && rmt_ack) |=> ready);
    // R6: launch while busy flags the error
    a_r6_busy_err: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && rmt_req) |=> err);
    // R7: error is sticky
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
    // R10: remote write does not disturb read data
    a_r10_wr_keeps_rd: assert property (@(posedge clk) disable iff (!rst_n)
        (rmt_req && rmt_we) |=> $stable(rd_val));
endmodule

// File: rtl/reg_window_bridge.sv
module reg_window_bridge #(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic [2:0]    host_ofs,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          rmt_req,
    output logic          rmt_we,
    output logic [AW-1:0] rmt_addr,
    output logic [DW-1:0] rmt_wdata,
    output logic [PW-1:0] rmt_ctl,
    input  logic          rmt_ack,
    input  logic [DW-1:0] rmt_rdata
);
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdat_q;
    logic [DW-1:0] rd_val;
    logic          launch, launch_dir, ready, err, dir;

    brw_window #(.AW(AW), .DW(DW), .PW(PW)) u_win (
        .clk(clk), .rst_n(rst_n), .wr(host_wr), .ofs(host_ofs),
        .wdata(host_wdata), .rdata(host_rdata),
        .addr_q(addr_q), .wdat_q(wdat_q), .par_q(rmt_ctl),
        .launch(launch), .launch_dir(launch_dir),
        .rd_val(rd_val), .ready(ready), .err(err), .dir(dir)
    );

    brw_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n), .launch(launch), .launch_dir(launch_dir),
        .addr_in(addr_q), .wdat_in(wdat_q),
        .rmt_req(rmt_req), .rmt_we(rmt_we), .rmt_addr(rmt_addr),
        .rmt_wdata(rmt_wdata), .rmt_ack(rmt_ack), .rmt_rdata(rmt_rdata),
        .ready(ready), .err(err), .dir(dir), .rd_val(rd_val)
    );
endmodule

// File: tb/sim_reg_window_bridge.sv
module sim_reg_window_bridge;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int PW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_wr = 1'b0;
    logic [2:0]    host_ofs = 3'd0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic          rmt_req, rmt_we;
    logic [AW-1:0] rmt_addr;
    logic [DW-1:0] rmt_wdata;
    logic [PW-1:0] rmt_ctl;
    logic          rmt_ack = 1'b0;
    logic [DW-1:0] rmt_rdata = '0;

    int vectors = 0;
    int fails = 0;
    bit hold_ack = 1'b0;
    bit finished = 1'b0;
    int ack_cnt = 0;
    int delay = 1;
    logic [DW-1:0] rmem [16];
    logic [DW-1:0] shadow [16];

    always #10 clk = ~clk;

    reg_window_bridge #(.AW(AW), .DW(DW), .PW(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_ofs(host_ofs),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .rmt_req(rmt_req), .rmt_we(rmt_we), .rmt_addr(rmt_addr),
        .rmt_wdata(rmt_wdata), .rmt_ctl(rmt_ctl),
        .rmt_ack(rmt_ack), .rmt_rdata(rmt_rdata)
    );

    // remote register model: one-cycle ack after a random wait
    always @(negedge clk) begin
        if (rmt_ack) begin
            rmt_ack = 1'b0;
        end else if (rmt_req && !hold_ack) begin
            if (delay <= 0) begin
                rmt_ack = 1'b1;
                ack_cnt++;
                if (rmt_we) rmem[rmt_addr[3:0]] = rmt_wdata;
                else        rmt_rdata = rmem[rmt_addr[3:0]];
                delay = int'($urandom_range(0, 5));
            end else begin
                delay--;
            end
        end
    end

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hwrite(logic [2:0] o, logic [DW-1:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_ofs = o; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(logic [2:0] o, output logic [DW-1:0] v);
        host_ofs = o;
        #1;
        v = host_rdata;
    endtask

    function automatic logic [DW-1:0] csr_val(bit d, bit rdy, bit e);
        return {{(DW-3){1'b0}}, e, rdy, d};
    endfunction

    task automatic wait_ready(output bit ok);
        logic [DW-1:0] v;
        ok = 1'b0;
        for (int i = 0; i < 50; i++) begin
            hread(3'd3, v);
            if (v[1]) begin ok = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        vectors++;
        fails++;
        $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        logic [DW-1:0] last_rd;
        bit ok;
        void'($urandom(32'd4242));
        for (int i = 0; i < 16; i++) begin rmem[i] = '0; shadow[i] = '0; end
        do_reset();

        // R1 reset state
        hread(3'd3, v); check("R1 csr", v & 32'h6, 32'h2);
        hread(3'd0, v); check("R1 addr", v, 0);
        hread(3'd1, v); check("R1 wdata", v, 0);
        hread(3'd2, v); check("R1 rdata", v, 0);
        hread(3'd4, v); check("R1 par", v, 0);

        // R2 readback, R8 parity drive
        hwrite(3'd0, 32'hFFFF_1234); hread(3'd0, v); check("R2 addr", v, 32'h1234);
        hwrite(3'd1, 32'hCAFE_BABE); hread(3'd1, v); check("R2 wdata", v, 32'hCAFE_BABE);
        hwrite(3'd4, 32'h0000_00FA); hread(3'd4, v); check("R2 par", v, 32'hA);
        check("R8 rmt_ctl", {28'd0, rmt_ctl}, 32'hA);

        // R3 directed write to address 3
        hwrite(3'd0, 32'd3); hwrite(3'd1, 32'h1111_2222);
        delay = 2;
        hwrite(3'd3, 32'd1);
        check("R3 req", {31'd0, rmt_req}, 1);
        check("R3 we", {31'd0, rmt_we}, 1);
        check("R3 addr", {16'd0, rmt_addr}, 3);
        check("R3 wdata", rmt_wdata, 32'h1111_2222);
        hread(3'd3, v); check("R5 ready low", {31'd0, v[1]}, 0);
        wait_ready(ok); check("R5 ready rises", {31'd0, ok}, 1);
        shadow[3] = 32'h1111_2222;
        check("R3 remote stored", rmem[3], 32'h1111_2222);
        hread(3'd2, v); check("R10 rdata kept", v, 0);

        // R4 directed read of address 3
        hwrite(3'd0, 32'd3);
        hwrite(3'd3, 32'd0);
        check("R4 we low", {31'd0, rmt_we}, 0);
        check("R4 req", {31'd0, rmt_req}, 1);
        wait_ready(ok);
        hread(3'd2, v); check("R4 rdata", v, 32'h1111_2222);
        hread(3'd3, v); check("R4 csr dir", v & 32'h7, csr_val(0, 1, 0));
        last_rd = 32'h1111_2222;

        // random mix: R3, R4, R10
        for (int n = 0; n < 60; n++) begin
            logic [3:0] a;
            logic [DW-1:0] d;
            bit w;
            a = 4'($urandom_range(0, 15));
            d = $urandom();
            w = 1'($urandom_range(0, 1));
            hwrite(3'd0, {28'd0, a});
            hwrite(3'd1, d);
            hwrite(3'd3, {31'd0, w});
            check(w ? "R3 rand addr" : "R4 rand addr", {16'd0, rmt_addr}, {28'd0, a});
            wait_ready(ok);
            check("R5 rand ready", {31'd0, ok}, 1);
            if (w) begin
                shadow[a] = d;
                hread(3'd2, v); check("R10 rand rdata kept", v, last_rd);
            end else begin
                last_rd = shadow[a];
                hread(3'd2, v); check("R4 rand rdata", v, shadow[a]);
            end
        end
        hread(3'd3, v); check("R7 no err yet", {31'd0, v[2]}, 0);

        // R6 / R9 busy collision
        hold_ack = 1'b1;
        hwrite(3'd0, 32'd5); hwrite(3'd1, 32'h5555_AAAA);
        hwrite(3'd3, 32'd1);
        hwrite(3'd0, 32'd9);
        hwrite(3'd1, 32'h0BAD_0BAD);
        check("R9 addr held", {16'd0, rmt_addr}, 5);
        check("R9 wdata held", rmt_wdata, 32'h5555_AAAA);
        hwrite(3'd3, 32'd0);
        check("R6 we held", {31'd0, rmt_we}, 1);
        check("R6 addr held", {16'd0, rmt_addr}, 5);
        hread(3'd3, v); check("R6 csr err busy", v & 32'h7, csr_val(1, 0, 1));
        v = ack_cnt;
        delay = 0;
        hold_ack = 1'b0;
        wait_ready(ok);
        check("R6 completes", {31'd0, ok}, 1);
        repeat (4) @(negedge clk);
        check("R6 no second req", {31'd0, rmt_req}, 0);
        check("R6 one ack", ack_cnt - v, 1);
        check("R6 remote data", rmem[5], 32'h5555_AAAA);
        shadow[5] = 32'h5555_AAAA;

        // R7 sticky across a further transaction
        hwrite(3'd0, 32'd5);
        hwrite(3'd3, 32'd0);
        wait_ready(ok);
        hread(3'd3, v); check("R7 err sticky", {31'd0, v[2]}, 1);
        hread(3'd2, v); check("R4 after err", v, 32'h5555_AAAA);
        do_reset();
        hread(3'd3, v); check("R7 cleared by reset", v & 32'h6, 32'h2);
        check("R8 ctl after reset", {28'd0, rmt_ctl}, 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule